// File: doc/BRIEF.md
# Dual-Channel Output Limiter and Offset Stage

This block is the last digital conditioning step in front of a two-channel converter. Each clock it may accept one signed 16-bit sample per channel (A and B), marked by a valid flag. An optional symmetric limiter comes first. When the limiter is switched on, it clamps each sample to plus or minus 128 times an 8-bit level. A signed offset, set separately for each channel, is then added. The sum saturates to the 16-bit signed range.

Settings are loaded through a single-cycle write port. A 2-bit select picks one of four words:

| Select | Word |
|---|---|
| 0 | control; bit 0 turns the limiter on |
| 1 | limiter level in bits 7:0 |
| 2 | channel A offset, full 16 bits |
| 3 | channel B offset, full 16 bits |

Each sample carries a copy of the settings that were in force in the cycle it entered. A write therefore never changes a sample that is already inside the pipeline.

Top module: `dual_out_cond`

## Requirements
- R1: When control bit 0 is clear, the limiter passes each sample through unchanged, whatever the level holds.
- R2: When control bit 0 is set, each sample is clamped to the range [-128*L, +128*L], where L is the unsigned 8-bit level written with select 1. A sample already inside that range is unchanged.
- R3: Both channels use the same enable and the same level.
- R4: With the limiter on and L = 0, the limiter output is zero, so the block's output equals the channel offset.
- R5: A per-channel two's-complement offset (select 2 for A, select 3 for B) is added after the limiter. An offset of 0x0000 leaves the sample unchanged.
- R6: The offset covers the whole range from 0x8000 (-32768) to 0x7FFF (+32767).
- R7: The sum of the limited sample and the offset saturates to -32768..+32767 and never wraps.
- R8: out_valid is high exactly two cycles after each cycle in which in_valid is high, and low otherwise.
- R9: A write takes effect for samples presented in the cycle after the write. A sample presented in the same cycle as a write uses the old settings.
- R10: Reset clears the enable, the level and both offsets. It also drops out_valid and zeroes the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Write strobe for the settings |
| cfg_sel | input | 2 | Settings word select (0 control, 1 level, 2 offset A, 3 offset B) |
| cfg_data | input | 16 | Write data |
| in_valid | input | 1 | Input samples valid |
| in_a | input | 16 | Channel A sample, signed |
| in_b | input | 16 | Channel B sample, signed |
| out_valid | output | 1 | Output samples valid |
| out_a | output | 16 | Channel A result, signed |
| out_b | output | 16 | Channel B result, signed |

## Verification
The assertions assume that rst_n is released synchronously to clk. They also assume that in_valid, the samples and the write port are stable around each rising edge, since every property compares one registered stage with what its inputs held at the previous edge. The bench meets these conditions by holding in_valid and cfg_wr low during reset and by changing every input only on the falling edge. The random phase mixes idle cycles, writes landing in the same cycle as samples, and extreme sample and offset values, so the clamp, saturation and settings-ordering properties all see real traffic.

// File: rtl/dual_out_cond_pkg.sv
package dual_out_cond_pkg;
  parameter int SMP_W     = 16;  // sample and offset width
  parameter int LVL_W     = 8;   // limiter level width
  parameter int LVL_SHIFT = 7;   // level scale: window = level << LVL_SHIFT
  parameter int NCH       = 2;   // channels
  parameter int SEL_W     = 2;

  localparam logic [SEL_W-1:0] SEL_CTRL  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LEVEL = 2'd1;
  localparam logic [SEL_W-1:0] SEL_OFS_A = 2'd2;
  localparam logic [SEL_W-1:0] SEL_OFS_B = 2'd3;

  typedef logic [SMP_W-1:0] smp_t;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/dual_out_cond_regs.sv
module dual_out_cond_regs
  import dual_out_cond_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [SMP_W-1:0]       cfg_data,
  output logic                   clip_on,
  output lvl_t                   clip_lvl,
  output logic [NCH-1:0][SMP_W-1:0] ofs
);
  logic                        clip_on_d;
  lvl_t                        clip_lvl_d;
  logic [NCH-1:0][SMP_W-1:0]   ofs_d;

  always_comb begin
    clip_on_d  = clip_on;
    clip_lvl_d = clip_lvl;
    ofs_d      = ofs;
    if (cfg_wr) begin
      unique case (cfg_sel)
        SEL_CTRL:  clip_on_d  = cfg_data[0];
        SEL_LEVEL: clip_lvl_d = cfg_data[LVL_W-1:0];
        SEL_OFS_A: ofs_d[0]   = cfg_data;
        SEL_OFS_B: ofs_d[1]   = cfg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clip_on  <= 1'b0;
      clip_lvl <= '0;
      ofs      <= '0;
    end else if (cfg_wr) begin
      clip_on  <= clip_on_d;
      clip_lvl <= clip_lvl_d;
      ofs      <= ofs_d;
    end
  end

  // R9: a write lands on the following edge
  assert_wr_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_sel == SEL_LEVEL |=> clip_lvl == $past(cfg_data[LVL_W-1:0]));
endmodule

// File: rtl/dual_out_cond_clip.sv
module dual_out_cond_clip
  import dual_out_cond_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NCH-1:0][SMP_W-1:0] din,
  input  logic                      clip_on,
  input  lvl_t                      clip_lvl,
  input  logic [NCH-1:0][SMP_W-1:0] ofs_in,
  output logic                      v_q,
  output logic [NCH-1:0][SMP_W-1:0] smp_q,
  output logic [NCH-1:0][SMP_W-1:0] ofs_q
);
  localparam int EXT_W = SMP_W + 1;

  logic signed [EXT_W-1:0]     lim_pos, lim_neg;
  logic [NCH-1:0][SMP_W-1:0]   smp_d;

  always_comb begin
    lim_pos = $signed({{(EXT_W-LVL_W){1'b0}}, clip_lvl} << LVL_SHIFT);
    lim_neg = -lim_pos;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [EXT_W-1:0] x_ext;
    always_comb begin
      x_ext     = $signed({din[ch][SMP_W-1], din[ch]});
      smp_d[ch] = din[ch];
      if (clip_on) begin
        if (x_ext > lim_pos)      smp_d[ch] = lim_pos[SMP_W-1:0];
        else if (x_ext < lim_neg) smp_d[ch] = lim_neg[SMP_W-1:0];
      end
    end

    // R2/R3/R4: limiter output inside the shared window
    assert_clip_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clip_on |=>
        ($signed({smp_q[ch][SMP_W-1], smp_q[ch]}) <= $past(lim_pos)) &&
        ($signed({smp_q[ch][SMP_W-1], smp_q[ch]}) >= $past(lim_neg)));
    // R1: bypass when the limiter is off
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !clip_on |=> smp_q[ch] == $past(din[ch]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      ofs_q <= '0;
    end else if (in_valid) begin
      smp_q <= smp_d;
      ofs_q <= ofs_in;
    end
  end
endmodule

// File: rtl/dual_out_cond_ofs.sv
module dual_out_cond_ofs
  import dual_out_cond_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NCH-1:0][SMP_W-1:0] din,
  input  logic [NCH-1:0][SMP_W-1:0] ofs,
  output logic                      v_q,
  output logic [NCH-1:0][SMP_W-1:0] dout_q
);
  localparam logic [SMP_W-1:0] S_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] S_MIN = {1'b1, {(SMP_W-1){1'b0}}};

  logic [NCH-1:0][SMP_W-1:0] dout_d;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SMP_W:0] sum;
    always_comb begin
      sum = {din[ch][SMP_W-1], din[ch]} + {ofs[ch][SMP_W-1], ofs[ch]};
      if (sum[SMP_W] != sum[SMP_W-1]) dout_d[ch] = sum[SMP_W] ? S_MIN : S_MAX;
      else                            dout_d[ch] = sum[SMP_W-1:0];
    end

    // R5: zero offset is transparent
    assert_zero_ofs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ofs[ch] == '0 |=> dout_q[ch] == $past(din[ch]));
    // R7: no wrap; sign of offset gives direction of change
    assert_no_wrap_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !ofs[ch][SMP_W-1] |=> $signed(dout_q[ch]) >= $signed($past(din[ch])));
    assert_no_wrap_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && ofs[ch][SMP_W-1] |=> $signed(dout_q[ch]) <= $signed($past(din[ch])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (in_valid) dout_q <= dout_d;
  end
endmodule

// File: rtl/dual_out_cond.sv
module dual_out_cond
  import dual_out_cond_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [15:0]      cfg_data,
  input  logic             in_valid,
  input  logic [15:0]      in_a,
  input  logic [15:0]      in_b,
  output logic             out_valid,
  output logic [15:0]      out_a,
  output logic [15:0]      out_b
);
  logic                      clip_on;
  lvl_t                      clip_lvl;
  logic [NCH-1:0][SMP_W-1:0] ofs_reg, ofs_s1, smp_in, smp_s1, smp_out;
  logic                      v_s1;

  assign smp_in = {in_b, in_a};

  dual_out_cond_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .clip_on(clip_on), .clip_lvl(clip_lvl), .ofs(ofs_reg)
  );

  dual_out_cond_clip u_clip (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(smp_in),
    .clip_on(clip_on), .clip_lvl(clip_lvl), .ofs_in(ofs_reg),
    .v_q(v_s1), .smp_q(smp_s1), .ofs_q(ofs_s1)
  );

  dual_out_cond_ofs u_ofs (
    .clk(clk), .rst_n(rst_n), .in_valid(v_s1), .din(smp_s1), .ofs(ofs_s1),
    .v_q(out_valid), .dout_q(smp_out)
  );

  assign out_a = smp_out[0];
  assign out_b = smp_out[1];

  // R8: valid emerges exactly two edges later
  assert_lag_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  assert_lag_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/dual_out_cond_bench.sv
`timescale 1ns/1ps
module dual_out_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [15:0] out_a, out_b;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  typedef struct { int a; int b; int due; string tag; } exp_t;
  exp_t q[$];

  // shadow settings
  bit sh_en = 0; int sh_lvl = 0; int sh_oa = 0; int sh_ob = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  dual_out_cond u_dual_out_cond (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
  );

  function automatic int s16(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic int model(input int x, input int ofs);
    int y;
    y = x;
    if (sh_en) begin
      if (y > sh_lvl * 128) y = sh_lvl * 128;
      if (y < -sh_lvl * 128) y = -sh_lvl * 128;
    end
    y = y + ofs;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle of stimulus: optional write, optional sample
  task automatic step(input bit wr, input logic [1:0] sel, input logic [15:0] data,
                      input bit smp, input int a, input int b, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr = wr; cfg_sel = sel; cfg_data = data;
    in_valid = smp; in_a = 16'(a); in_b = 16'(b);
    if (smp) begin
      e.a = model(a, sh_oa); e.b = model(b, sh_ob);
      e.due = cyc + 2; e.tag = tag;
      q.push_back(e);
    end
    if (wr) begin  // settings apply to later samples only (R9)
      case (sel)
        2'd0: sh_en = data[0];
        2'd1: sh_lvl = int'(data[7:0]);
        2'd2: sh_oa = s16(data);
        default: sh_ob = s16(data);
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    step(1, sel, data, 0, 0, 0, "");
  endtask
  task automatic send(input int a, input int b, input string tag);
    step(0, 2'd0, 16'd0, 1, a, b, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 16'd0, 0, 0, 0, "");
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check("R8 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " R8 latency"}, cyc, e.due);
          check({e.tag, " chA"}, s16(out_a), e.a);
          check({e.tag, " chB"}, s16(out_b), e.b);
        end
      end else if (q.size() != 0 && q[0].due <= cyc) begin
        check("R8 missing out_valid", 0, 1);
        void'(q.pop_front());
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid in reset", int'(out_valid), 0);
    check("R10 out_a in reset", s16(out_a), 0);
    check("R10 out_b in reset", s16(out_b), 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: cleared settings -> pass through, no offset
    send(32767, -32768, "R10 post-reset passthrough");
    send(1234, -4321, "R10 post-reset passthrough");
    idle(3);

    // R1: limiter off ignores level
    wr(2'd1, 16'd10);
    send(30000, -30000, "R1 bypass large");
    send(1281, -1281, "R1 bypass");
    idle(3);

    // R2 / R3: limiter on, level 100 -> window +/-12800
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd100);
    send(20000, -20000, "R2 clamp both R3");
    send(12800, -12800, "R2 at edge");
    send(12801, -12801, "R2 just outside");
    send(5000, -7, "R2 inside");
    send(-32768, 32767, "R3 swapped extremes");
    idle(3);

    // R4: level 0 -> limiter output zero, output equals offset
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd55);
    wr(2'd3, 16'hFFF0);
    send(9999, -9999, "R4 zero level");
    idle(3);

    // R5: offsets added after limiter
    wr(2'd1, 16'd1);                   // window +/-128
    wr(2'd2, 16'd100);
    wr(2'd3, 16'(-250));
    send(1000, -1000, "R5 offset after clip");
    wr(2'd0, 16'd0);
    wr(2'd2, 16'd0);
    send(-3000, 3000, "R5 zero offset A");
    idle(3);

    // R6: full offset range
    wr(2'd2, 16'h8000);
    wr(2'd3, 16'h7FFF);
    send(0, 0, "R6 offset extremes");
    send(1, -1, "R6 offset extremes near zero");
    idle(3);

    // R7: saturation, no wrap
    wr(2'd0, 16'd1);
    wr(2'd1, 16'd255);                 // window +/-32640
    wr(2'd2, 16'h7FFF);
    wr(2'd3, 16'h8000);
    send(32767, -32768, "R7 saturate");
    send(-32768, 32767, "R7 cancel");
    idle(3);

    // R9: write in the same cycle as a sample uses old setting
    wr(2'd2, 16'd0); wr(2'd3, 16'd0);
    wr(2'd1, 16'd10);                  // window +/-1280
    step(1, 2'd1, 16'd20, 1, 5000, -5000, "R9 same-cycle old level");
    send(5000, -5000, "R9 next-cycle new level");
    step(1, 2'd2, 16'd300, 1, 100, 100, "R9 same-cycle old offset");
    send(100, 100, "R9 next-cycle new offset");
    idle(3);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) step(1, 2'($urandom_range(0, 3)), 16'($urandom), 1,
                       s16(16'($urandom)), s16(16'($urandom)), "R9 random");
      else if (r < 3) idle(1);
      else send(s16(16'($urandom)), s16(16'($urandom)), "R2 R7 random");
    end
    idle(4);
    check("R8 queue drained", q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule